// File: doc/BRIEF.md
# IOMMU translation lookaside buffer

This block caches recent address translations for device-initiated memory traffic. A lookup carries the requester (source) identifier, a virtual page number and an access kind. If a cached translation matches, the block returns the physical page, page size and permission bits one cycle later and says whether the access kind is allowed. If nothing matches, it raises a miss pulse, which starts a page table walk in an external walker. The walker later delivers its result on the install port.

Entries of 4 KB, 2 MB and 1 GB coexist in one fully associative array. Larger pages compare fewer address bits. Software keeps the cache coherent with three invalidation scopes: everything, one source, or one source plus a page address. Two rules keep a stale mapping from being used. An invalidation takes effect before a lookup made in the same cycle. A walk result that an invalidation has overtaken is dropped. Two free-running counters record lookup hits and misses.

Top module: `iotlb_cache`

## Requirements
- R1: A lookup (`lk_valid` high) gives exactly one of `res_hit` or `res_miss` on the following cycle. A hit means a live entry has the same source identifier and the same page number under that entry's size mask. A hit returns that entry's size and permission bits. With `lk_valid` low, both `res_hit` and `res_miss` are low on the following cycle.
- R2: The size code sets how many low page-number bits the match ignores: 0 is 4 KB (none ignored), 1 is 2 MB (the low 9 bits), and 2 or 3 is 1 GB (the low 18 bits). The returned physical page takes the ignored low bits from the lookup's page number and all other bits from the entry.
- R3: The permission bits are: bit 0 read, bit 1 write, bit 2 execute. The access kind codes are: 0 read, 1 write, 2 execute. `res_allow` is high only on a hit whose entry has the bit for the access kind set. Access kind 3 is never allowed.
- R4: When several live entries match a lookup, the one with the lowest index answers.
- R5: An accepted install is visible to lookups from the next cycle. The entry it writes is chosen in this order:
  - a live entry with the same source, size and masked page number is overwritten, and the replacement pointer stays unchanged;
  - otherwise, the lowest free entry is written;
  - otherwise, the entry under the replacement pointer is evicted.
  
  In the last two cases the pointer advances by one, wrapping at the entry count. Nothing else moves the pointer.
- R6: Invalidation kind 0 removes every entry. Kind 1 removes the entries of one source. Kind 2 removes the entries of one source whose page, under the entry's own size mask, contains the given page number. Kind 3 has no effect.
- R7: An invalidation and a lookup in the same cycle are ordered invalidation first, so the lookup misses on any entry being removed.
- R8: An install is discarded in two cases. The first is when the invalidation in the same cycle covers it. The second is when an invalidation has covered the most recent miss since that miss was signalled. For kind 2, "covered" means the same source and equal page-number bits above the 1 GB boundary.
- R9: `hit_count` and `miss_count` each add one for every lookup that hits or misses, and wrap at their width.
- R10: After reset, all entries are invalid, both counters are zero, all result outputs are low and the replacement pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_sid | input | SID_W | Lookup source identifier |
| lk_vpn | input | VPN_W | Lookup virtual page number (4 KB units) |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| inv_valid | input | 1 | Invalidation request |
| inv_kind | input | 2 | 0 global, 1 by source, 2 by source and page, 3 none |
| inv_sid | input | SID_W | Invalidation source identifier |
| inv_vpn | input | VPN_W | Invalidation page number |
| ins_valid | input | 1 | Walker result install |
| ins_sid | input | SID_W | Install source identifier |
| ins_vpn | input | VPN_W | Install virtual page number |
| ins_ppn | input | PPN_W | Install physical page number |
| ins_size | input | 2 | Install page size code |
| ins_perm | input | 3 | Install permissions {exec, write, read} |
| res_hit | output | 1 | Lookup hit (one cycle after request) |
| res_miss | output | 1 | Lookup miss, walk request |
| res_ppn | output | PPN_W | Physical page on hit |
| res_size | output | 2 | Page size code on hit |
| res_perm | output | 3 | Permission bits on hit |
| res_allow | output | 1 | Access kind permitted on hit |
| hit_count | output | CNT_W | Hit counter |
| miss_count | output | CNT_W | Miss counter |

## Verification
A corrupted tag, size or valid bit shows on the very next lookup to that page. It appears as a miss where a hit was due, as a hit after an invalidation, or as wrong low bits of the physical page. A replacement pointer that drifts does not show at the install. It shows only when a full cache evicts the wrong entry, so the bench fills the array and then probes every tag. A lost stale-walk flag lets a dropped install land. The bench therefore looks up the same page in the cycle after each such install, and the fault appears there as a hit. The counters are compared after every cycle, so a missed increment is reported at once.

// File: rtl/iotlb_cache.sv
module iotlb_cache #(
  parameter int ENTRIES = 16,
  parameter int SID_W   = 16,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 28,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [SID_W-1:0] lk_sid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [1:0]       lk_acc,
  input  logic             inv_valid,
  input  logic [1:0]       inv_kind,
  input  logic [SID_W-1:0] inv_sid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             ins_valid,
  input  logic [SID_W-1:0] ins_sid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [1:0]       ins_size,
  input  logic [2:0]       ins_perm,
  output logic             res_hit,
  output logic             res_miss,
  output logic [PPN_W-1:0] res_ppn,
  output logic [1:0]       res_size,
  output logic [2:0]       res_perm,
  output logic             res_allow,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int HI_W  = VPN_W - 18;

  function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
    size_mask = '1;
    if (sz == 2'd1) size_mask[8:0] = '0;
    else if (sz != 2'd0) size_mask[17:0] = '0;
  endfunction

  logic [ENTRIES-1:0] e_v;
  logic [SID_W-1:0]   e_sid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [1:0]         e_sz  [ENTRIES];
  logic [2:0]         e_pm  [ENTRIES];

  logic [ENTRIES-1:0] kill, live, lhit, same;
  logic [IDX_W-1:0]   hit_idx, free_idx, same_idx, ins_idx, rr_ptr;
  logic [SID_W-1:0]   pend_sid;
  logic [HI_W-1:0]    pend_hi;
  logic               pend_stale;

  wire inv_on = inv_valid && inv_kind != 2'd3;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign kill[i] = inv_on && e_v[i] && (inv_kind == 2'd0 || (e_sid[i] == inv_sid &&
                     (inv_kind == 2'd1 || ((e_vpn[i] ^ inv_vpn) & size_mask(e_sz[i])) == '0)));
    assign live[i] = e_v[i] && !kill[i];
    assign lhit[i] = live[i] && e_sid[i] == lk_sid &&
                     ((e_vpn[i] ^ lk_vpn) & size_mask(e_sz[i])) == '0;
    assign same[i] = live[i] && e_sid[i] == ins_sid && e_sz[i] == ins_size &&
                     ((e_vpn[i] ^ ins_vpn) & size_mask(ins_size)) == '0;
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lhit[i]) hit_idx = IDX_W'(i);
      if (!live[i]) free_idx = IDX_W'(i);
      if (same[i]) same_idx = IDX_W'(i);
    end
  end

  wire any_hit  = |lhit;
  wire any_same = |same;
  wire any_free = ~&live;
  assign ins_idx = any_same ? same_idx : (any_free ? free_idx : rr_ptr);

  wire ins_clash = inv_on && (inv_kind == 2'd0 || (inv_sid == ins_sid &&
                   (inv_kind == 2'd1 || ((ins_vpn ^ inv_vpn) & size_mask(ins_size)) == '0)));
  wire ins_ok    = ins_valid && !pend_stale && !ins_clash;
  wire pend_hit  = inv_on && (inv_kind == 2'd0 || (inv_sid == pend_sid &&
                   (inv_kind == 2'd1 || inv_vpn[VPN_W-1:18] == pend_hi)));

  wire [VPN_W-1:0] hmask = size_mask(e_sz[hit_idx]);
  wire [PPN_W-1:0] lo    = PPN_W'(~hmask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v        <= '0;
      rr_ptr     <= '0;
      pend_sid   <= '0;
      pend_hi    <= '0;
      pend_stale <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_ppn    <= '0;
      res_size   <= '0;
      res_perm   <= '0;
      res_allow  <= 1'b0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      e_v <= live;
      if (ins_ok) begin
        e_v[ins_idx] <= 1'b1;
        if (!any_same) rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
      if (lk_valid && !any_hit) begin
        pend_sid   <= lk_sid;
        pend_hi    <= lk_vpn[VPN_W-1:18];
        pend_stale <= 1'b0;
      end else if (pend_hit) begin
        pend_stale <= 1'b1;
      end
      res_hit   <= lk_valid && any_hit;
      res_miss  <= lk_valid && !any_hit;
      res_ppn   <= any_hit ? ((e_ppn[hit_idx] & ~lo) | (PPN_W'(lk_vpn) & lo)) : '0;
      res_size  <= any_hit ? e_sz[hit_idx] : '0;
      res_perm  <= any_hit ? e_pm[hit_idx] : '0;
      res_allow <= lk_valid && any_hit && |(e_pm[hit_idx] & (3'b001 << lk_acc));
      if (lk_valid && any_hit) hit_count <= hit_count + 1'b1;
      if (lk_valid && !any_hit) miss_count <= miss_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      e_sid[ins_idx] <= ins_sid;
      e_vpn[ins_idx] <= ins_vpn;
      e_ppn[ins_idx] <= ins_ppn;
      e_sz[ins_idx]  <= ins_size;
      e_pm[ins_idx]  <= ins_perm;
    end
  end

  assert_hit_xor_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (res_hit ^ res_miss));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_hit && !res_miss));
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(rr_ptr));
  assert_global_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == 2'd0 && !ins_valid) |=> (e_v == '0));
  assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && pend_stale && !inv_valid) |=> ($countones(e_v) == $countones($past(e_v))));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

// File: tb/test_iotlb_cache.sv
module test_iotlb_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, inv_valid = 0, ins_valid = 0;
  logic [15:0] lk_sid = 0, inv_sid = 0, ins_sid = 0;
  logic [35:0] lk_vpn = 0, inv_vpn = 0, ins_vpn = 0;
  logic [1:0]  lk_acc = 0, inv_kind = 0, ins_size = 0;
  logic [27:0] ins_ppn = 0;
  logic [2:0]  ins_perm = 0;
  logic res_hit, res_miss, res_allow;
  logic [27:0] res_ppn;
  logic [1:0]  res_size;
  logic [2:0]  res_perm;
  logic [31:0] hit_count, miss_count;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  iotlb_cache i_iotlb_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_sid(lk_sid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
    .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_sid(inv_sid), .inv_vpn(inv_vpn),
    .ins_valid(ins_valid), .ins_sid(ins_sid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
    .ins_size(ins_size), .ins_perm(ins_perm),
    .res_hit(res_hit), .res_miss(res_miss), .res_ppn(res_ppn), .res_size(res_size),
    .res_perm(res_perm), .res_allow(res_allow), .hit_count(hit_count), .miss_count(miss_count));

  bit          m_v [16];
  logic [15:0] m_sid [16];
  logic [35:0] m_vpn [16];
  logic [27:0] m_ppn [16];
  logic [1:0]  m_sz [16];
  logic [2:0]  m_pm [16];
  int          m_ptr = 0;
  logic [15:0] psid = 0;
  logic [17:0] phi = 0;
  bit          pstale = 0;
  logic [31:0] ehc = 0, emc = 0;

  function automatic logic [35:0] msk(input logic [1:0] s);
    msk = '1;
    if (s == 2'd1) msk[8:0] = '0;
    else if (s != 2'd0) msk[17:0] = '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit lv, input logic [15:0] sid, input logic [35:0] vpn, input logic [1:0] acc,
                       input bit iv, input logic [1:0] ik, input logic [15:0] isid, input logic [35:0] ivpn,
                       input bit nv, input logic [15:0] nsid, input logic [35:0] nvpn,
                       input logic [27:0] nppn, input logic [1:0] nsz, input logic [2:0] npm);
    bit live [16];
    int h, tgt;
    bit ehit, emiss, eal, clash, ok, ion;
    logic [27:0] eppn, lo;
    logic [1:0] esz;
    logic [2:0] epm;
    lk_valid = lv; lk_sid = sid; lk_vpn = vpn; lk_acc = acc;
    inv_valid = iv; inv_kind = ik; inv_sid = isid; inv_vpn = ivpn;
    ins_valid = nv; ins_sid = nsid; ins_vpn = nvpn; ins_ppn = nppn; ins_size = nsz; ins_perm = npm;
    ion = iv && ik != 2'd3;
    for (int i = 0; i < 16; i++)
      live[i] = m_v[i] && !(ion && (ik == 2'd0 || (m_sid[i] == isid &&
                (ik == 2'd1 || ((m_vpn[i] ^ ivpn) & msk(m_sz[i])) == '0))));
    h = -1;
    for (int i = 15; i >= 0; i--)
      if (live[i] && m_sid[i] == sid && ((m_vpn[i] ^ vpn) & msk(m_sz[i])) == '0) h = i;
    ehit = lv && h >= 0;
    emiss = lv && h < 0;
    eppn = 0; esz = 0; epm = 0; eal = 0;
    if (h >= 0) begin
      lo = 28'(~msk(m_sz[h]));
      eppn = (m_ppn[h] & ~lo) | (vpn[27:0] & lo);
      esz = m_sz[h];
      epm = m_pm[h];
      eal = lv && |(epm & (3'b001 << acc));
    end
    if (ehit) ehc++;
    if (emiss) emc++;
    clash = ion && (ik == 2'd0 || (isid == nsid && (ik == 2'd1 || ((nvpn ^ ivpn) & msk(nsz)) == '0)));
    ok = nv && !pstale && !clash;
    if (emiss) begin
      psid = sid; phi = vpn[35:18]; pstale = 0;
    end else if (ion && (ik == 2'd0 || (isid == psid && (ik == 2'd1 || ivpn[35:18] == phi))))
      pstale = 1;
    for (int i = 0; i < 16; i++) m_v[i] = live[i];
    if (ok) begin
      tgt = -1;
      for (int i = 15; i >= 0; i--)
        if (live[i] && m_sid[i] == nsid && m_sz[i] == nsz && ((m_vpn[i] ^ nvpn) & msk(nsz)) == '0) tgt = i;
      if (tgt < 0) begin
        for (int i = 15; i >= 0; i--) if (!live[i]) tgt = i;
        if (tgt < 0) tgt = m_ptr;
        m_ptr = (m_ptr + 1) % 16;
      end
      m_v[tgt] = 1; m_sid[tgt] = nsid; m_vpn[tgt] = nvpn; m_ppn[tgt] = nppn; m_sz[tgt] = nsz; m_pm[tgt] = npm;
    end
    @(negedge clk);
    chk(res_hit == ehit, "R1 hit", 64'(res_hit), 64'(ehit));
    chk(res_miss == emiss, "R1 miss", 64'(res_miss), 64'(emiss));
    chk(res_allow == eal, "R3 allow", 64'(res_allow), 64'(eal));
    if (ehit) begin
      chk(res_ppn == eppn, "R2 ppn", 64'(res_ppn), 64'(eppn));
      chk(res_size == esz, "R1 size", 64'(res_size), 64'(esz));
      chk(res_perm == epm, "R1 perm", 64'(res_perm), 64'(epm));
    end
    chk(hit_count == ehc, "R9 hits", 64'(hit_count), 64'(ehc));
    chk(miss_count == emc, "R9 misses", 64'(miss_count), 64'(emc));
  endtask

  task automatic look(input logic [15:0] s, input logic [35:0] v, input logic [1:0] a);
    drive(1, s, v, a, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic inst(input logic [15:0] s, input logic [35:0] v, input logic [27:0] p,
                      input logic [1:0] z, input logic [2:0] m);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, s, v, p, z, m);
  endtask
  task automatic inval(input logic [1:0] k, input logic [15:0] s, input logic [35:0] v);
    drive(0, 0, 0, 0, 1, k, s, v, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic logic [35:0] rvpn();
    rvpn = (36'($urandom_range(0, 3)) << 18) | (36'($urandom_range(0, 3)) << 9) | 36'($urandom_range(0, 3));
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!res_hit && !res_miss && !res_allow, "R10 outputs", {res_hit, res_miss, res_allow}, 0);
    chk(hit_count == 0 && miss_count == 0, "R10 counters", {hit_count, miss_count}, 0);
    rst_n = 1'b1;
    look(16'd1, 36'h2A5, 0);                          // R10: empty cache misses
    // R2: 2 MB and 1 GB entries with low bits from the lookup
    inst(16'd1, 36'h200, 28'hABC00, 2'd1, 3'b011);
    look(16'd1, 36'h2A5, 2'd1);
    look(16'd1, 36'h2A5, 2'd2);                       // R3: no execute permission
    look(16'd1, 36'h2A5, 2'd3);                       // R3: kind 3 never allowed
    inst(16'd1, 36'h40000, 28'h3C0000, 2'd2, 3'b100);
    look(16'd1, 36'h7FFFF, 2'd2);
    look(16'd2, 36'h2A5, 0);                          // other source misses
    // R4: overlapping 4 KB entry at a higher index loses to the 2 MB entry
    inst(16'd1, 36'h2A5, 28'h111, 2'd0, 3'b111);
    look(16'd1, 36'h2A5, 2'd2);
    // R5: same tag overwrites in place
    inst(16'd1, 36'h200, 28'hDEE00, 2'd1, 3'b001);
    look(16'd1, 36'h201, 0);
    // R6: kind 3 has no effect; kind 2 honours the entry size
    inval(2'd3, 16'd1, 36'h200);
    look(16'd1, 36'h200, 0);
    inval(2'd2, 16'd1, 36'h3FF);
    look(16'd1, 36'h2A5, 0);
    // R5: fill all 16 entries, then evict at the pointer
    inval(2'd0, 0, 0);
    for (int i = 0; i < 17; i++) inst(16'd2, 36'(i), 28'(i + 100), 2'd0, 3'b001);
    for (int i = 0; i < 17; i++) look(16'd2, 36'(i), 0);
    // R7: invalidation wins over a same-cycle lookup
    drive(1, 16'd2, 36'd5, 0, 1, 2'd1, 16'd2, 0, 0, 0, 0, 0, 0, 0);
    look(16'd2, 36'd5, 0);
    // R8: walk overtaken by an invalidation is dropped
    look(16'd3, 36'h1234, 0);
    inval(2'd2, 16'd3, 36'h1234);
    inst(16'd3, 36'h1234, 28'h55, 2'd0, 3'b111);
    look(16'd3, 36'h1234, 0);
    inst(16'd3, 36'h1234, 28'h56, 2'd0, 3'b111);      // fresh miss above clears the flag
    look(16'd3, 36'h1234, 0);
    // R8: same-cycle covering invalidation drops the install
    drive(0, 0, 0, 0, 1, 2'd1, 16'd4, 0, 1, 16'd4, 36'h9, 28'h9, 2'd0, 3'b001);
    look(16'd4, 36'h9, 0);
    // random mix
    for (int n = 0; n < 4000; n++)
      drive($urandom_range(0, 9) < 7, 16'($urandom_range(0, 2)), rvpn(), 2'($urandom_range(0, 3)),
            $urandom_range(0, 24) == 0, 2'($urandom_range(0, 3)), 16'($urandom_range(0, 2)), rvpn(),
            $urandom_range(0, 9) < 3, 16'($urandom_range(0, 2)), rvpn(), 28'($urandom),
            2'($urandom_range(0, 2)), 3'($urandom_range(0, 7)));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule